// File: doc/BRIEF.md
# Write-Only Serial Clock-Enable Control Slave

This block is the serial control port of a clock-distribution device. A fast system clock oversamples the two-wire bus (SCL and an open-drain SDA). The block detects START and STOP conditions, matches the write address byte 0xD2, and acknowledges the bytes it accepts by pulling SDA low for the ninth clock. After the address come two prefix bytes whose contents are ignored. The data bytes that follow are stored strictly in arrival order into a small bank of enable registers. Each register bit switches one clock output on (1) or off (0).

The port cannot be read back and has no register index. To change the second register, the host must send the first one again. The block has no streaming interface: the bus side is the open-drain pin pair, and the result is a plain parallel enable vector that holds its value between transfers.

Top module: `clkgen_ctrl_slave`

## Requirements
- R1: After reset every bit of `clk_en_o` is 1 and `sda_pull_o` is 0.
- R2: An address byte of 0xD2, received MSB first, is acknowledged: `sda_pull_o` is 1 while SCL is high for the ninth clock of that byte.
- R3: An address byte other than 0xD2 (wrong upper seven bits, or read bit 1) is not acknowledged. Every later byte up to the next START is also not acknowledged and changes no register.
- R4: The two bytes that follow an accepted address are acknowledged, and their contents never reach `clk_en_o`.
- R5: The first data byte is stored in `clk_en_o[7:0]`, with bit 7 enabling output 15 down to bit 0 enabling output 8.
- R6: The second data byte is stored in `clk_en_o[15:8]`. Bit 15 enables output 17, bit 14 enables output 16, and bits 13:8 are reserved but stored as written.
- R7: Data bytes after the second are acknowledged and discarded.
- R8: A repeated START abandons the current transfer. The next byte is matched as an address, and the prefix and data counts begin again.
- R9: A STOP, including one that arrives in the middle of a byte, ends the transfer. Registers not yet reached, and a partly received byte, leave `clk_en_o` unchanged.
- R10: `sda_pull_o` is released at the falling SCL edge that ends the acknowledge clock. It is low again before the next data bit is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| clk_en_o | output | 16 | Output enable bits, data byte 1 in [7:0], byte 2 in [15:8] |

## Verification
A wrong internal state shows up at the ports within one byte time, in one of two ways. A wrong byte position or prefix count either stores a prefix byte, or places a data byte in the wrong half of `clk_en_o`. A wrong address or skip state either drops an acknowledge on the ninth clock or adds one where none belongs. The bench compares the acknowledge at the ninth clock of every byte, and compares the enable vector after every STOP. A stuck acknowledge is therefore caught one bit time after the ninth clock, and a misrouted byte is caught at the end of its transfer.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PREFIX,
    ST_DATA,
    ST_SKIP
  } link_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] scl_pipe, sda_pipe;
  logic         scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[TOP-1:0], scl_in};
      sda_pipe <= {sda_pipe[TOP-1:0], sda_in};
      scl_d    <= scl_pipe[TOP];
      sda_d    <= sda_pipe[TOP];
    end
  end

  assign scl_s     = scl_pipe[TOP];
  assign sda_s     = sda_pipe[TOP];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  // R8: a bus condition is only ever flagged while SCL was high one cycle earlier
  p_cond_scl_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |-> $past(scl_pipe[TOP]));
endmodule

// File: rtl/i2c_link.sv
module i2c_link
  import clkctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR     = 7'h69,
  parameter int         PREFIX_BYTES = 2,
  parameter int         NUM_REGS     = 2,
  localparam int        CW           = $clog2(NUM_REGS + 1),
  localparam int        PW           = $clog2(PREFIX_BYTES + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  output logic          sda_pull,
  output logic          wr_en,
  output logic [CW-1:0] wr_idx,
  output logic [7:0]    wr_data
);
  localparam logic [7:0] WR_ADDR = {DEV_ADDR, 1'b0};

  link_st_e      state;
  logic [3:0]    bit_cnt;
  logic [7:0]    shreg;
  logic          ack_q;
  logic [PW-1:0] pre_cnt;
  logic [CW-1:0] reg_idx;
  logic          active;

  assign active   = (state == ST_ADDR) || (state == ST_PREFIX) || (state == ST_DATA);
  assign sda_pull = ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      ack_q   <= 1'b0;
      pre_cnt <= '0;
      reg_idx <= '0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        ack_q   <= 1'b0;
        pre_cnt <= '0;
        reg_idx <= '0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        bit_cnt <= '0;
        ack_q   <= 1'b0;
      end else if (active) begin
        if (ack_q) begin
          if (scl_fall) begin
            ack_q   <= 1'b0;
            bit_cnt <= '0;
          end
        end else if (scl_rise && bit_cnt < 4'd8) begin
          shreg   <= {shreg[6:0], sda_s};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (scl_fall && bit_cnt == 4'd8) begin
          case (state)
            ST_ADDR: begin
              if (shreg == WR_ADDR) begin
                ack_q <= 1'b1;
                state <= (PREFIX_BYTES == 0) ? ST_DATA : ST_PREFIX;
              end else begin
                state   <= ST_SKIP;
                bit_cnt <= '0;
              end
            end
            ST_PREFIX: begin
              ack_q   <= 1'b1;
              pre_cnt <= pre_cnt + 1'b1;
              if (pre_cnt == PW'(PREFIX_BYTES - 1)) state <= ST_DATA;
            end
            default: begin
              ack_q <= 1'b1;
              if (reg_idx < CW'(NUM_REGS)) begin
                wr_en   <= 1'b1;
                wr_idx  <= reg_idx;
                wr_data <= shreg;
                reg_idx <= reg_idx + 1'b1;
              end
            end
          endcase
        end
      end
    end
  end

  // R2: the acknowledge is only ever raised right after an SCL falling edge
  p_pull_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(scl_fall));
  // R10: an active acknowledge is dropped at the falling edge that ends it
  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && scl_fall && !start_det) |=> !ack_q);
  // R8: a START never leaves SDA pulled
  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !ack_q);
  // R4: register writes only come out of the data phase
  p_write_in_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(state) == ST_DATA);
endmodule

// File: rtl/ctrl_bank.sv
module ctrl_bank #(
  parameter int         NUM_REGS  = 2,
  parameter logic [7:0] RESET_VAL = 8'hFF,
  localparam int        CW        = $clog2(NUM_REGS + 1),
  localparam int        QW        = NUM_REGS * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  output logic [QW-1:0] q
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              q[g*8 +: 8] <= RESET_VAL;
      else if (wr_en && wr_idx == CW'(g))      q[g*8 +: 8] <= wr_data;
    end
  end

  // R9: no write strobe, no change of any enable bit
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/clkgen_ctrl_slave.sv
module clkgen_ctrl_slave #(
  parameter logic [6:0] DEV_ADDR     = 7'h69,
  parameter int         PREFIX_BYTES = 2,
  parameter int         NUM_REGS     = 2,
  parameter int         SYNC_STAGES  = 2,
  localparam int        CW           = $clog2(NUM_REGS + 1),
  localparam int        QW           = NUM_REGS * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_pull_o,
  output logic [QW-1:0] clk_en_o
);
  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          wr_en;
  logic [CW-1:0] wr_idx;
  logic [7:0]    wr_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_link #(
    .DEV_ADDR     (DEV_ADDR),
    .PREFIX_BYTES (PREFIX_BYTES),
    .NUM_REGS     (NUM_REGS)
  ) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_pull  (sda_pull_o),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
  );

  ctrl_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .q       (clk_en_o)
  );

  // R3/R1: SDA is never pulled during an address phase before any byte completes
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull_o);
endmodule

// File: tb/test_clkgen_ctrl_slave.sv
`timescale 1ns/1ps
module test_clkgen_ctrl_slave;
  localparam int H = 10;
  // vector: {address, data0, data1, data2, number of data bytes}
  localparam logic [39:0] VEC [5] = '{
    {8'hD2, 8'hAA, 8'h55, 8'h00, 8'd2},
    {8'hD3, 8'h11, 8'h22, 8'h00, 8'd2},
    {8'hA4, 8'h33, 8'h44, 8'h00, 8'd2},
    {8'hD2, 8'h0F, 8'h00, 8'h00, 8'd1},
    {8'hD2, 8'h3C, 8'hC3, 8'h77, 8'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  logic [15:0] en;
  logic [15:0] exp_q = 16'hFFFF;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clkgen_ctrl_slave i_clkgen_ctrl_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl),
    .sda_in     (sda_m & ~sda_pull),
    .sda_pull_o (sda_pull),
    .clk_en_o   (en)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic do_start;
    sda_m = 1'b1; tick(H); scl = 1'b1; tick(H); sda_m = 1'b0; tick(H); scl = 1'b0; tick(H);
  endtask

  task automatic do_stop;
    sda_m = 1'b0; tick(H); scl = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 0; i < nb; i++) begin
      sda_m = b[7-i]; tick(H); scl = 1'b1; tick(H); scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    logic got;
    send_bits(b, 8);
    sda_m = 1'b1; tick(H); scl = 1'b1; tick(H/2);
    got = sda_pull;
    tick(H/2); scl = 1'b0;
    chk(got == exp_ack, req, {15'd0, got}, {15'd0, exp_ack});
    tick(H);
    chk(sda_pull == 1'b0, "R10", {15'd0, sda_pull}, 16'd0);
  endtask

  task automatic prefixes;
    send_byte(8'hE1, 1'b1, "R4");
    send_byte(8'h1E, 1'b1, "R4");
  endtask

  initial begin
    tick(5);
    chk(en == 16'hFFFF, "R1", en, 16'hFFFF);
    chk(sda_pull == 1'b0, "R1", {15'd0, sda_pull}, 16'd0);
    rst_n = 1'b1;
    tick(5);

    // table walk: R2 R3 R5 R6 R7
    for (int v = 0; v < 5; v++) begin
      logic [7:0] a, nb;
      logic [7:0] d [3];
      bit ok_addr;
      a = VEC[v][39:32]; d[0] = VEC[v][31:24]; d[1] = VEC[v][23:16];
      d[2] = VEC[v][15:8]; nb = VEC[v][7:0];
      ok_addr = (a == 8'hD2);
      do_start;
      send_byte(a, ok_addr, ok_addr ? "R2" : "R3");
      if (ok_addr) begin
        prefixes;
        for (int k = 0; k < int'(nb); k++) begin
          send_byte(d[k], 1'b1, k < 2 ? "R5" : "R7");
          if (k == 0) exp_q[7:0]  = d[k];
          if (k == 1) exp_q[15:8] = d[k];
        end
      end else begin
        send_byte(d[0], 1'b0, "R3");
      end
      do_stop;
      tick(H);
      chk(en == exp_q, ok_addr ? "R6" : "R3", en, exp_q);
    end

    // R4: prefix-only write changes nothing
    do_start; send_byte(8'hD2, 1'b1, "R2"); prefixes; do_stop; tick(H);
    chk(en == exp_q, "R4", en, exp_q);

    // R8: repeated START restarts address and counts
    do_start; send_byte(8'hD2, 1'b1, "R2"); send_byte(8'h5A, 1'b1, "R4");
    do_start; send_byte(8'hD2, 1'b1, "R8"); prefixes;
    send_byte(8'h99, 1'b1, "R8"); exp_q[7:0] = 8'h99;
    do_start; send_byte(8'hD2, 1'b1, "R8"); prefixes;
    send_byte(8'h12, 1'b1, "R8"); exp_q[7:0] = 8'h12;
    do_start; send_byte(8'hD2, 1'b1, "R8"); prefixes;
    send_byte(8'h34, 1'b1, "R8"); send_byte(8'h81, 1'b1, "R6");
    exp_q = 16'h8134;
    do_stop; tick(H);
    chk(en == exp_q, "R8", en, exp_q);

    // R9: STOP in the middle of a data byte
    do_start; send_byte(8'hD2, 1'b1, "R2"); prefixes;
    send_bits(8'h00, 4); do_stop; tick(H);
    chk(en == exp_q, "R9", en, exp_q);

    // R3: after a read address, a following START still works
    do_start; send_byte(8'hD3, 1'b0, "R3"); send_byte(8'hD2, 1'b0, "R3");
    do_start; send_byte(8'hD2, 1'b1, "R8"); prefixes;
    send_byte(8'hC0, 1'b1, "R5"); exp_q[7:0] = 8'hC0;
    do_stop; tick(H);
    chk(en == exp_q, "R5", en, exp_q);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule